// File: doc/BRIEF.md
# Conditional Floating-Point Move Condition Evaluator

This block decides whether a conditional floating-point register move should be carried out. The caller presents a 32-bit instruction word together with the current condition state. That state is the floating-point status word, which holds four 2-bit comparison codes, a byte carrying the 32-bit and 64-bit integer flag sets, and the value of the integer register named by the instruction. The block recognises three instruction forms. One tests a floating-point comparison code. One tests the integer flags. One tests the sign and zero state of a register value.

One cycle after a valid instruction is presented, the block returns a verdict. `move_taken` tells the caller to perform the move. `move_skip` tells the caller to retire the instruction as a no-op. When the word is not one of the three forms, both stay low and the caller handles the word elsewhere. Reading registers and moving the data are left to the caller.

Top module: `cfm_cond_eval`

## Requirements
- R1: After reset, and until the first valid input, `out_valid`, `move_taken` and `move_skip` are all 0.
- R2: `out_valid` is high in the cycle after `in_valid` is high and low otherwise. While `out_valid` is low, `move_taken` and `move_skip` are both 0.
- R3: A word is recognised only when insn[31:30]=2'b10 and insn[24:19]=6'b110101. Among recognised words, the forms are picked as follows. insn[13]=0 with insn[10:5]=6'b000011 is the FP-code form. insn[13]=1 with insn[10:5]=6'b000011 is the integer-flag form. insn[9:5]=5'b00111 is the register form. Any other word gives taken=0 and skip=0.
- R4: In the FP-code form, insn[12:11] picks the code. Index 0 reads status bits 11:10, index 1 reads bits 33:32, index 2 reads bits 35:34 and index 3 reads bits 37:36.
- R5: FP code values mean 0 equal, 1 less, 2 greater and 3 unordered. insn[16:14] picks the test: 0 never, 1 not equal, 2 less or greater, 3 unordered or less, 4 less, 5 unordered or greater, 6 greater, 7 unordered.
- R6: In both the FP-code form and the integer-flag form, insn[17]=1 inverts the result of the test.
- R7: In the integer-flag form, insn[12]=1 uses int_cc[7:4] (the 64-bit set) and insn[12]=0 uses int_cc[3:0]. Within each set, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R8: In the integer-flag form, insn[16:14] picks the test: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V.
- R9: In the register form, insn[11:10] picks the test, with the value read as signed: 0 never, 1 equal to zero, 2 less than or equal to zero, 3 less than zero. insn[12]=1 inverts the result.
- R10: In the register form, when the register number insn[18:14] is 0, the value is taken as zero whatever `src_reg_val` holds.
- R11: For a recognised word, exactly one of `move_taken` and `move_skip` is high, and `move_skip` is the inverse of `move_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and condition inputs are valid this cycle |
| insn | input | 32 | Instruction word |
| fp_status | input | 38 | Floating-point status word holding the four comparison codes |
| int_cc | input | 8 | Integer flags: the 64-bit set in [7:4], the 32-bit set in [3:0] |
| src_reg_val | input | 64 | Value of the integer register named by insn[18:14] |
| out_valid | output | 1 | Verdict is valid |
| move_taken | output | 1 | The move must be performed |
| move_skip | output | 1 | The instruction must be retired as a no-op |

## Verification
The bench builds the block with its default parameters. These give four FP code fields, two 4-bit integer flag sets and a 64-bit register value. With these values, the upper code fields at bits 32 to 37 and the sign bit at position 63 can both be driven directly. The vector table places a distinguishing value in only the selected code field or flag set, so a wrong selection shows up as a wrong verdict. Directed steps cover the reset state, idle cycles, the register-zero override with a non-zero value on the port, and words that fail the major opcode check.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FCC  = 2'd1,
        SRC_ICC  = 2'd2,
        SRC_REG  = 2'd3
    } src_e;

    typedef struct packed {
        logic vld;
        logic take;
        logic skip;
    } verdict_t;

    localparam logic [1:0] FCC_EQ = 2'd0;
    localparam logic [1:0] FCC_LT = 2'd1;
    localparam logic [1:0] FCC_GT = 2'd2;
    localparam logic [1:0] FCC_UN = 2'd3;
endpackage

// File: rtl/cfm_fcc_test.sv
module cfm_fcc_test #(
    parameter int STAT_W   = 38,
    parameter int NUM_FCC  = 4,
    parameter int FCC0_LSB = 10,
    parameter int FCCX_LSB = 30
) (
    input  logic [STAT_W-1:0]          stat,
    input  logic [$clog2(NUM_FCC)-1:0] idx,
    input  logic [2:0]                 cond,
    output logic                       hit
);
    import cfm_pkg::*;

    logic [1:0] codes [NUM_FCC];

    // Field 0 sits low in the word; the others are packed above FCCX_LSB.
    for (genvar g = 0; g < NUM_FCC; g++) begin : g_code
        if (g == 0) begin : g_first
            assign codes[g] = stat[FCC0_LSB +: 2];
        end else begin : g_rest
            assign codes[g] = stat[FCCX_LSB + 2*g +: 2];
        end
    end

    logic [1:0] sel;
    assign sel = codes[idx];

    always_comb begin
        case (cond)
            3'd0:    hit = 1'b0;
            3'd1:    hit = (sel != FCC_EQ);
            3'd2:    hit = (sel == FCC_LT) || (sel == FCC_GT);
            3'd3:    hit = (sel == FCC_UN) || (sel == FCC_LT);
            3'd4:    hit = (sel == FCC_LT);
            3'd5:    hit = (sel == FCC_UN) || (sel == FCC_GT);
            3'd6:    hit = (sel == FCC_GT);
            default: hit = (sel == FCC_UN);
        endcase
    end
endmodule

// File: rtl/cfm_icc_test.sv
module cfm_icc_test #(
    parameter int CC_W = 4
) (
    input  logic [2*CC_W-1:0] ccs,
    input  logic              wide,
    input  logic [2:0]        cond,
    output logic              hit
);
    logic [CC_W-1:0] cc;
    logic n_f, z_f, v_f, c_f;

    assign cc  = wide ? ccs[CC_W +: CC_W] : ccs[0 +: CC_W];
    assign n_f = cc[3];
    assign z_f = cc[2];
    assign v_f = cc[1];
    assign c_f = cc[0];

    always_comb begin
        case (cond)
            3'd0:    hit = 1'b0;
            3'd1:    hit = z_f;
            3'd2:    hit = z_f | (n_f ^ v_f);
            3'd3:    hit = n_f ^ v_f;
            3'd4:    hit = c_f | z_f;
            3'd5:    hit = c_f;
            3'd6:    hit = n_f;
            default: hit = v_f;
        endcase
    end
endmodule

// File: rtl/cfm_reg_test.sv
module cfm_reg_test #(
    parameter int REG_W = 64,
    parameter int RNUM_W = 5
) (
    input  logic [REG_W-1:0]  value,
    input  logic [RNUM_W-1:0] rnum,
    input  logic [1:0]        rcond,
    output logic              hit
);
    logic [REG_W-1:0] eff;
    logic is_zero, is_neg;

    assign eff     = (rnum == '0) ? '0 : value;
    assign is_zero = (eff == '0);
    assign is_neg  = eff[REG_W-1];

    always_comb begin
        case (rcond)
            2'd0:    hit = 1'b0;
            2'd1:    hit = is_zero;
            2'd2:    hit = is_zero | is_neg;
            default: hit = is_neg;
        endcase
    end
endmodule

// File: rtl/cfm_cond_eval.sv
module cfm_cond_eval #(
    parameter int STAT_W = 38,
    parameter int CC_W   = 4,
    parameter int REG_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [STAT_W-1:0] fp_status,
    input  logic [2*CC_W-1:0] int_cc,
    input  logic [REG_W-1:0]  src_reg_val,
    output logic              out_valid,
    output logic              move_taken,
    output logic              move_skip
);
    import cfm_pkg::*;

    localparam int NUM_FCC = 4;
    localparam int IDX_W   = $clog2(NUM_FCC);

    logic major_ok;
    src_e src;
    logic fcc_hit, icc_hit, reg_hit;
    logic raw, flip, verdict;

    assign major_ok = (insn[31:30] == 2'b10) && (insn[24:19] == 6'b110101);

    always_comb begin
        src = SRC_NONE;
        if (major_ok) begin
            if (insn[10:5] == 6'b000011)
                src = insn[13] ? SRC_ICC : SRC_FCC;
            else if (insn[9:5] == 5'b00111)
                src = SRC_REG;
        end
    end

    cfm_fcc_test #(
        .STAT_W(STAT_W), .NUM_FCC(NUM_FCC), .FCC0_LSB(10), .FCCX_LSB(30)
    ) u_fcc (
        .stat(fp_status), .idx(insn[11 +: IDX_W]), .cond(insn[16:14]), .hit(fcc_hit)
    );

    cfm_icc_test #(.CC_W(CC_W)) u_icc (
        .ccs(int_cc), .wide(insn[12]), .cond(insn[16:14]), .hit(icc_hit)
    );

    cfm_reg_test #(.REG_W(REG_W), .RNUM_W(5)) u_reg (
        .value(src_reg_val), .rnum(insn[18:14]), .rcond(insn[11:10]), .hit(reg_hit)
    );

    always_comb begin
        case (src)
            SRC_FCC: begin raw = fcc_hit; flip = insn[17]; end
            SRC_ICC: begin raw = icc_hit; flip = insn[17]; end
            SRC_REG: begin raw = reg_hit; flip = insn[12]; end
            default: begin raw = 1'b0;    flip = 1'b0;     end
        endcase
        verdict = raw ^ flip;
    end

    verdict_t state_d, state_q;

    always_comb begin
        state_d = '0;
        if (in_valid) begin
            state_d.vld = 1'b1;
            if (src != SRC_NONE) begin
                state_d.take = verdict;
                state_d.skip = ~verdict;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign move_taken = state_q.take;
    assign move_skip  = state_q.skip;
endmodule

// File: rtl/cfm_cond_eval_chk.sv
module cfm_cond_eval_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic        out_valid,
    input logic        move_taken,
    input logic        move_skip
);
    logic major;
    assign major = (insn[31:30] == 2'b10) && (insn[24:19] == 6'b110101);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!move_taken && !move_skip));

    p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(move_taken && move_skip));

    p_fcc_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major && !insn[13] && insn[10:5] == 6'b000011 && insn[17:14] == 4'b0000)
        |=> (move_skip && !move_taken));

    p_reg_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && major && insn[9:5] == 5'b00111 && insn[18:14] == 5'd0 && insn[12:10] == 3'b001)
        |=> move_taken);

    p_bad_major_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !major) |=> (!move_taken && !move_skip));
endmodule

bind cfm_cond_eval cfm_cond_eval_chk i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .out_valid(out_valid), .move_taken(move_taken), .move_skip(move_skip)
);

// File: tb/test_cfm_cond_eval.sv
module test_cfm_cond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [37:0] fp_status = '0;
    logic [7:0]  int_cc = '0;
    logic [63:0] src_reg_val = '0;
    logic        out_valid, move_taken, move_skip;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    cfm_cond_eval i_cfm_cond_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .fp_status(fp_status), .int_cc(int_cc), .src_reg_val(src_reg_val),
        .out_valid(out_valid), .move_taken(move_taken), .move_skip(move_skip)
    );

    // form: 0 FP code, 1 integer flags, 2 register, 3 not a conditional move
    // exp : {taken, skip}
    typedef struct packed {
        logic [1:0]  form;
        logic        inv;
        logic [2:0]  cnd;
        logic [1:0]  sel;
        logic [4:0]  rnum;
        logic [7:0]  fccs;
        logic [7:0]  icc;
        logic [63:0] rv;
        logic [1:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 3'd1, 2'd0, 5'd0, 8'h00, 8'h00, 64'd0, 2'b01, 4'd5},  // R5 ne, equal
        '{2'd0, 1'b0, 3'd1, 2'd2, 5'd0, 8'h10, 8'h00, 64'd0, 2'b10, 4'd4},  // R4 idx 2
        '{2'd0, 1'b0, 3'd3, 2'd3, 5'd0, 8'hC0, 8'h00, 64'd0, 2'b10, 4'd4},  // R4 idx 3
        '{2'd0, 1'b0, 3'd6, 2'd1, 5'd0, 8'h04, 8'h00, 64'd0, 2'b01, 4'd5},  // R5 gt on less
        '{2'd0, 1'b1, 3'd0, 2'd0, 5'd0, 8'h00, 8'h00, 64'd0, 2'b10, 4'd6},  // R6 never inverted
        '{2'd0, 1'b1, 3'd7, 2'd0, 5'd0, 8'h03, 8'h00, 64'd0, 2'b01, 4'd6},  // R6 unord inverted
        '{2'd0, 1'b0, 3'd2, 2'd0, 5'd0, 8'h02, 8'h00, 64'd0, 2'b10, 4'd5},  // R5 lg on greater
        '{2'd1, 1'b0, 3'd1, 2'd0, 5'd0, 8'h00, 8'h04, 64'd0, 2'b10, 4'd8},  // R8 Z
        '{2'd1, 1'b0, 3'd1, 2'd1, 5'd0, 8'h00, 8'h04, 64'd0, 2'b01, 4'd7},  // R7 wide set clear
        '{2'd1, 1'b0, 3'd3, 2'd1, 5'd0, 8'h00, 8'h80, 64'd0, 2'b10, 4'd7},  // R7 wide N
        '{2'd1, 1'b0, 3'd2, 2'd0, 5'd0, 8'h00, 8'h0A, 64'd0, 2'b01, 4'd8},  // R8 le N=V
        '{2'd1, 1'b0, 3'd4, 2'd0, 5'd0, 8'h00, 8'h01, 64'd0, 2'b10, 4'd8},  // R8 leu C
        '{2'd1, 1'b1, 3'd7, 2'd0, 5'd0, 8'h00, 8'h02, 64'd0, 2'b01, 4'd6},  // R6 V inverted
        '{2'd1, 1'b0, 3'd6, 2'd0, 5'd0, 8'h00, 8'h08, 64'd0, 2'b10, 4'd8},  // R8 N
        '{2'd1, 1'b0, 3'd5, 2'd0, 5'd0, 8'h00, 8'h00, 64'd0, 2'b01, 4'd8},  // R8 C clear
        '{2'd2, 1'b0, 3'd1, 2'd0, 5'd3, 8'h00, 8'h00, 64'd0, 2'b10, 4'd9},  // R9 zero
        '{2'd2, 1'b0, 3'd3, 2'd0, 5'd3, 8'h00, 8'h00, 64'h8000_0000_0000_0000, 2'b10, 4'd9},  // R9 lt
        '{2'd2, 1'b0, 3'd2, 2'd0, 5'd3, 8'h00, 8'h00, 64'd5, 2'b01, 4'd9},  // R9 le positive
        '{2'd2, 1'b1, 3'd2, 2'd0, 5'd3, 8'h00, 8'h00, 64'd5, 2'b10, 4'd9},  // R9 inverted
        '{2'd2, 1'b0, 3'd1, 2'd0, 5'd0, 8'h00, 8'h00, 64'd5, 2'b10, 4'd10}, // R10 reg 0 zero
        '{2'd2, 1'b0, 3'd3, 2'd0, 5'd0, 8'h00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 4'd10}, // R10
        '{2'd3, 1'b0, 3'd0, 2'd0, 5'd0, 8'h00, 8'h00, 64'd0, 2'b00, 4'd3}   // R3 not recognised
    };

    localparam logic [31:0] BASE = 32'h81A8_0000;

    function automatic logic [31:0] build(vec_t v);
        logic [31:0] w;
        case (v.form)
            2'd0: w = BASE | (32'(v.inv) << 17) | (32'(v.cnd) << 14) | (32'(v.sel) << 11) | (32'd3 << 5);
            2'd1: w = BASE | (32'(v.inv) << 17) | (32'(v.cnd) << 14) | (32'd1 << 13)
                      | (32'(v.sel[0]) << 12) | (32'd3 << 5);
            2'd2: w = BASE | (32'(v.rnum) << 14) | (32'(v.inv) << 12) | (32'(v.cnd[1:0]) << 10)
                      | (32'd7 << 5);
            default: w = 32'h81A0_0060;
        endcase
        return w;
    endfunction

    function automatic logic [37:0] fsr_of(logic [7:0] c);
        logic [37:0] s = '0;
        s[11:10] = c[1:0];
        s[33:32] = c[3:2];
        s[35:34] = c[5:4];
        s[37:36] = c[7:6];
        return s;
    endfunction

    task automatic check(string req, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s {valid,taken,skip} actual=%b expected=%b", req, got, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", {out_valid, move_taken, move_skip}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, move_taken, move_skip}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            insn        = build(TBL[i]);
            fp_status   = fsr_of(TBL[i].fccs);
            int_cc      = TBL[i].icc;
            src_reg_val = TBL[i].rv;
            in_valid    = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", TBL[i].req, i),
                  {out_valid, move_taken, move_skip}, {1'b1, TBL[i].exp});
        end

        // R2: idle cycle clears the verdict
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", {out_valid, move_taken, move_skip}, 3'b000);

        // R3: a matching move field under a wrong major opcode is not recognised
        insn = build(TBL[1]) & ~32'h8000_0000;
        fp_status = fsr_of(8'h10);
        in_valid = 1'b1;
        @(negedge clk);
        check("R3 major", {out_valid, move_taken, move_skip}, 3'b100);

        // R11: back-to-back verdicts flip cleanly; R4 index 1
        insn = build(TBL[0]) | (32'd1 << 11);
        fp_status = fsr_of(8'h04);
        @(negedge clk);
        check("R11 taken", {out_valid, move_taken, move_skip}, 3'b110);
        fp_status = fsr_of(8'hF3);  // index 1 equal, others not
        @(negedge clk);
        check("R11 skip", {out_valid, move_taken, move_skip}, 3'b101);

        in_valid = 1'b0;
        @(negedge clk);
        check("R2 end", {out_valid, move_taken, move_skip}, 3'b000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule